// File: doc/BRIEF.md
# Preamble-and-Scrambled-Payload Frame Serializer

This block builds fixed-length transmit frames and shifts them out one bit per enable pulse. Every frame starts with a known synchronisation pattern: a 13-bit Barker word repeated twice, which is never scrambled. A payload field of 174 bits follows it. The payload bits are taken from an upstream source over a ready/valid handshake, and each one is combined by XOR with the output of an additive LFSR scrambler before it is sent. The scrambler restarts from a fixed seed in every frame, so a receiver can descramble each frame on its own.

A frame begins when a start request is seen on an enabled cycle while the block is idle. The first serial bit of that frame is produced in that same enabled cycle. If the request is still present at the next enabled cycle after the last bit, the next frame follows with no gap. The serial bit goes to a downstream bit-pairing stage, together with a bit-valid strobe and markers for the first and last bit of the frame. All outputs except the payload-ready signal are registered.

Top module: `barker_pkt_framer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `tx_valid`, `tx_sof`, `tx_eof` and `pl_ready` are all low.
- R2: While idle, an enabled cycle with `frame_req` low produces no output bit.
- R3: An enabled cycle in idle with `frame_req` high produces, one clock later, `tx_valid`=1 and `tx_sof`=1 with the first preamble bit. `tx_sof` is high on no other bit.
- R4: Frame bits 0 to 25 are the preamble: the pattern 1111100110101 sent twice, leftmost bit first. These bits are sent unscrambled, whatever the payload input carries.
- R5: `pl_ready` is high only in enabled cycles of the payload phase (frame bits 26 to 199). It is low in idle and during the preamble.
- R6: Payload bit j is `pl_data` XOR k. The key k is s[6]^s[3] of a 7-bit state s, and s then shifts left with k inserted at bit 0. This is the polynomial x^7+x^4+1. s is set to 7'h7F before the first payload bit of every frame.
- R7: In the payload phase, an enabled cycle with `pl_valid` low produces no output bit and does not advance the frame or the scrambler.
- R8: A frame is exactly 200 output bits. `tx_eof` marks the 200th bit (payload bit 174), and `tx_sof` and `tx_eof` are never high together.
- R9: When `frame_req` is high at the next enabled cycle after an end-of-frame bit, the next frame's first bit follows with no idle bit between the frames.
- R10: `tx_valid` is high only in the cycle after a cycle with `bit_en` high, so at most one bit is sent per enable.
- R11: A payload handshake (`pl_ready` and `pl_valid` both high) produces a non-start output bit in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Advance the frame by one bit this cycle |
| frame_req | input | 1 | Start a frame when idle |
| pl_data | input | 1 | Payload source bit |
| pl_valid | input | 1 | Payload source bit is present |
| pl_ready | output | 1 | Payload bit is taken this cycle if valid |
| tx_bit | output | 1 | Serial frame bit |
| tx_valid | output | 1 | `tx_bit` holds a new frame bit |
| tx_sof | output | 1 | First bit of a frame |
| tx_eof | output | 1 | Last bit of a frame |

## Verification
The assertions check the following on every cycle:
- the start and end markers are exclusive and appear only with a valid bit;
- output appears only after an enable, and every handshake yields a bit one cycle later;
- ready stays low beside a start bit;
- each end marker lands exactly 200 bits after its start, and the scrambler is reseeded and holds its state while no bit is taken.

The bench scenarios are the only place where the bit values are checked. They compare the preamble pattern, the scrambled payload against an independent keystream, stall behaviour under random enables and random source validity, and back-to-back frames under continuous requests.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_PAY  = 2'd2
  } phase_t;
endpackage

// File: rtl/pkt_preamble_rom.sv
module pkt_preamble_rom #(
  parameter int SEQ_LEN = 13,
  parameter logic [SEQ_LEN-1:0] SEQ = 13'b1111100110101,
  parameter int REPS = 2,
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic             pre_bit
);
  localparam int TBL_LEN = SEQ_LEN * REPS;
  localparam int TBL_W   = $clog2(TBL_LEN);

  logic [TBL_LEN-1:0] tbl;

  // Entry g holds the bit sent at frame position g, leftmost pattern bit first.
  for (genvar g = 0; g < TBL_LEN; g++) begin : g_tbl
    assign tbl[g] = SEQ[SEQ_LEN-1-(g % SEQ_LEN)];
  end

  assign pre_bit = (idx < IDX_W'(TBL_LEN)) ? tbl[idx[TBL_W-1:0]] : 1'b0;
endmodule

// File: rtl/pkt_scrambler.sv
module pkt_scrambler #(
  parameter int W   = 7,
  parameter int TAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic seed_load,
  input  logic step,
  output logic key
);
  logic [W-1:0] state;

  assign key = state[W-1] ^ state[TAP-1];

  always_ff @(posedge clk) begin
    if (rst || seed_load) state <= '1;
    else if (step)        state <= {state[W-2:0], key};
  end

  // R6: every frame restarts the keystream from the all-ones seed
  p_seed_all_ones_r6: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (state == '1));

  // R7: no consumed payload bit, no keystream advance
  p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && !step) |=> $stable(state));
endmodule

// File: rtl/barker_pkt_framer.sv
module barker_pkt_framer #(
  parameter int SEQ_LEN     = 13,
  parameter logic [SEQ_LEN-1:0] SEQ = 13'b1111100110101,
  parameter int PRE_REPS    = 2,
  parameter int PAYLOAD_LEN = 174,
  parameter int SCR_W       = 7,
  parameter int SCR_TAP     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic frame_req,
  input  logic pl_data,
  input  logic pl_valid,
  output logic pl_ready,
  output logic tx_bit,
  output logic tx_valid,
  output logic tx_sof,
  output logic tx_eof
);
  import pkt_pkg::*;

  localparam int PRE_LEN   = SEQ_LEN * PRE_REPS;
  localparam int FRAME_LEN = PRE_LEN + PAYLOAD_LEN;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam logic [POS_W-1:0] LAST_PRE = POS_W'(PRE_LEN - 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  phase_t           phase;
  logic [POS_W-1:0] pos;
  logic             pre_bit;
  logic             key;
  logic             seed_load;
  logic             take;

  assign pl_ready  = bit_en && (phase == PH_PAY);
  assign take      = pl_ready && pl_valid;
  assign seed_load = bit_en && (phase == PH_IDLE) && frame_req;

  pkt_preamble_rom #(
    .SEQ_LEN(SEQ_LEN), .SEQ(SEQ), .REPS(PRE_REPS), .IDX_W(POS_W)
  ) i_rom (
    .idx(pos), .pre_bit(pre_bit)
  );

  pkt_scrambler #(.W(SCR_W), .TAP(SCR_TAP)) i_scr (
    .clk(clk), .rst(rst), .seed_load(seed_load), .step(take), .key(key)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      pos      <= '0;
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
      tx_sof   <= 1'b0;
      tx_eof   <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      tx_sof   <= 1'b0;
      tx_eof   <= 1'b0;
      if (bit_en) begin
        unique case (phase)
          PH_IDLE: begin
            if (frame_req) begin
              tx_valid <= 1'b1;
              tx_sof   <= 1'b1;
              tx_bit   <= pre_bit;
              pos      <= POS_W'(1);
              phase    <= PH_PRE;
            end
          end
          PH_PRE: begin
            tx_valid <= 1'b1;
            tx_bit   <= pre_bit;
            pos      <= pos + POS_W'(1);
            if (pos == LAST_PRE) phase <= PH_PAY;
          end
          PH_PAY: begin
            if (pl_valid) begin
              tx_valid <= 1'b1;
              tx_bit   <= pl_data ^ key;
              if (pos == LAST_POS) begin
                tx_eof <= 1'b1;
                pos    <= '0;
                phase  <= PH_IDLE;
              end else begin
                pos <= pos + POS_W'(1);
              end
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // Independent bit counter used only by the frame-length check.
  logic [POS_W-1:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (rst)           chk_cnt <= '0;
    else if (tx_sof)   chk_cnt <= POS_W'(1);
    else if (tx_valid) chk_cnt <= chk_cnt + POS_W'(1);
  end

  p_markers_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(tx_sof && tx_eof));

  p_marker_has_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_sof || tx_eof) |-> tx_valid);

  p_one_bit_per_enable_r10: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bit_en));

  p_take_emits_bit_r11: assert property (@(posedge clk) disable iff (rst)
    take |=> (tx_valid && !tx_sof));

  p_no_ready_at_start_r5: assert property (@(posedge clk) disable iff (rst)
    tx_sof |-> !pl_ready);

  p_frame_length_r8: assert property (@(posedge clk) disable iff (rst)
    tx_eof |-> (chk_cnt == LAST_POS));
endmodule

// File: tb/test_barker_pkt_framer.sv
module test_barker_pkt_framer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, frame_req = 1'b0, pl_data = 1'b0, pl_valid = 1'b0;
  logic pl_ready, tx_bit, tx_valid, tx_sof, tx_eof;

  always #10 clk = ~clk;

  barker_pkt_framer i_barker_pkt_framer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_req(frame_req),
    .pl_data(pl_data), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof)
  );

  int tests = 0, fails = 0, frames_done = 0, b2b_seen = 0;
  bit done = 1'b0;

  // Bench model state, built from the requirements
  bit       m_busy = 0;
  int       m_pos = 0;
  logic [6:0] m_lfsr = 7'h7F;
  bit       last_eof = 0;
  bit       e_valid = 0, e_sof = 0, e_eof = 0, e_bit = 0;
  string    e_tag = "R10";

  function automatic bit pre_bit(int p);
    logic [12:0] w = 13'b1111100110101;
    return w[12 - (p % 13)];
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cycle(bit en, bit req, bit vld, bit d);
    bit exp_ready;
    @(negedge clk);
    check(e_tag, "tx_valid", tx_valid, e_valid);
    if (e_valid) begin
      check(e_sof ? (last_eof ? "R9" : "R3") : "R3", "tx_sof", tx_sof, e_sof);
      check("R8", "tx_eof", tx_eof, e_eof);
      check(e_tag, "tx_bit", tx_bit, e_bit);
    end else begin
      check("R10", "tx_sof idle", tx_sof, 1'b0);
      check("R10", "tx_eof idle", tx_eof, 1'b0);
    end
    if (e_valid) last_eof = e_eof;
    bit_en = en; frame_req = req; pl_valid = vld; pl_data = d;
    #5;
    exp_ready = en && m_busy && (m_pos >= 26);
    check("R5", "pl_ready", pl_ready, exp_ready);
    e_valid = 0; e_sof = 0; e_eof = 0; e_bit = 0; e_tag = "R10";
    if (en) begin
      if (!m_busy) begin
        e_tag = "R2";
        if (req) begin
          if (last_eof) b2b_seen++;
          e_valid = 1; e_sof = 1; e_bit = pre_bit(0); e_tag = "R4";
          m_busy = 1; m_pos = 1; m_lfsr = 7'h7F;
        end
      end else if (m_pos < 26) begin
        e_valid = 1; e_bit = pre_bit(m_pos); e_tag = "R4"; m_pos++;
      end else if (vld) begin
        bit k;
        k = m_lfsr[6] ^ m_lfsr[3];
        m_lfsr = {m_lfsr[5:0], k};
        e_valid = 1; e_bit = d ^ k; e_tag = "R6";
        if (m_pos == 199) begin
          e_eof = 1; m_busy = 0; m_pos = 0; frames_done++;
        end else m_pos++;
      end else begin
        e_tag = "R7";
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; bit_en = 1'b1; frame_req = 1'b1; pl_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "tx_valid in reset", tx_valid, 1'b0);
    check("R1", "tx_sof in reset", tx_sof, 1'b0);
    check("R1", "tx_eof in reset", tx_eof, 1'b0);
    check("R1", "pl_ready in reset", pl_ready, 1'b0);
    rst = 1'b0; bit_en = 1'b0; frame_req = 1'b0; pl_valid = 1'b0;
    // R2: idle, no request
    for (int i = 0; i < 60; i++) cycle($urandom % 4 != 0, 1'b0, $urandom % 2, $urandom % 2);
    // Random mix: R4 R5 R6 R7 R10 R11
    for (int i = 0; i < 4000; i++)
      cycle($urandom % 4 != 0, $urandom % 8 != 0, $urandom % 10 < 7, $urandom % 2);
    // Directed: continuous enables, zero data exposes keystream; R9 back-to-back
    for (int i = 0; i < 520; i++) cycle(1'b1, 1'b1, 1'b1, 1'b0);
    // Directed: preamble ignores payload input (R4) and stall in payload (R7)
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 200; i++) cycle(1'b1, 1'b0, 1'b1, $urandom % 2);
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    tests++;
    if (frames_done < 4) begin
      fails++;
      $display("FAIL R8 frames completed: actual %0d expected >= 4", frames_done);
    end
    tests++;
    if (b2b_seen < 1) begin
      fails++;
      $display("FAIL R9 back-to-back starts: actual %0d expected >= 1", b2b_seen);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule